// File: doc/BRIEF.md
# Four-Channel Time-Division Link

This block carries several single-bit source channels across one shared wire. A slot counter produces a rotating slot index. The same index drives two routers. The transmit router places the chosen source bit on the shared wire. The receive router copies the wire onto the destination output with the same index and forces every other destination output to zero. Each channel therefore owns the wire for one clock slot per rotation. The receive side only routes the bit it is given, so it can never create a one on its own.

The slot index is held in a register. It moves forward one step per clock while the enable pin is high, stays put while enable is low, and returns to slot 0 on a synchronous active-high reset. Routing from the inputs to the outputs is combinational within a slot. The sources are sampled every slot, so there is no valid/ready handshake and no back-pressure: a destination bit is meaningful only in the slot its index is active, and a consumer that misses that slot waits one full rotation. The channel count is a parameter with a default of 4.

Top module: `tdm_link`

## Requirements
- R1: One clock edge with `rst` high makes `slot_idx` equal 0 in the following cycle.
- R2: `line_out` always equals `src_in[slot_idx]`.
- R3: `dst_out[slot_idx]` equals `line_out`, and every other bit of `dst_out` is 0, so at most one bit of `dst_out` is high.
- R4: At each clock edge with `en` high and `rst` low, `slot_idx` steps through the sequence 0, 1, 2, 3.
- R5: At an edge with `en` high, `rst` low and `slot_idx` equal to NUM_CH-1 (3 by default), `slot_idx` becomes 0.
- R6: At an edge with `en` low and `rst` low, `slot_idx` keeps its value.
- R7: When the selected source bit is 0, all of `dst_out` is 0. The receive side never drives a 1 that was not on the wire.
- R8: Because both routers use the same slot index, `dst_out[slot_idx]` equals `src_in[slot_idx]` in every cycle.
- R9: When `rst` and `en` are both high at an edge, reset wins and `slot_idx` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the slot counter when high |
| src_in | input | NUM_CH | One source bit per channel |
| dst_out | output | NUM_CH | Destination bits. Only the current slot's bit can be high |
| line_out | output | 1 | The shared wire |
| slot_idx | output | $clog2(NUM_CH) | Current slot index |

## Verification
The bench builds the block with the default NUM_CH of 4. This makes the full rotation 0, 1, 2, 3 short, so the wrap from 3 to 0 is reached many times across several rotations. With only four channels, the bench can walk every single-hot source pattern, the all-ones and all-zeros patterns, and random patterns through every slot. It also covers paused stretches, and reset asserted in the same cycle as enable partway through a rotation.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned TDM_CH_DEFAULT = 4;

  function automatic int unsigned tdm_sel_width(input int unsigned ch);
    return (ch > 1) ? $clog2(ch) : 1;
  endfunction
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int unsigned NUM_CH = tdm_pkg::TDM_CH_DEFAULT,
  localparam int unsigned SEL_W = tdm_pkg::tdm_sel_width(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [SEL_W-1:0] slot_o
);
  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(NUM_CH - 1);

  logic [SEL_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst)
      slot_q <= '0;
    else if (en)
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
  end

  assign slot_o = slot_q;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (slot_q == '0)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (en && slot_q != LAST_SLOT) |=> (slot_q == SEL_W'($past(slot_q) + 1'b1))); // R4
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && slot_q == LAST_SLOT) |=> (slot_q == '0)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(slot_q)); // R6
endmodule

// File: rtl/tdm_tx_sel.sv
module tdm_tx_sel #(
  parameter int unsigned NUM_CH = tdm_pkg::TDM_CH_DEFAULT,
  localparam int unsigned SEL_W = tdm_pkg::tdm_sel_width(NUM_CH)
) (
  input  logic [NUM_CH-1:0] src_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              line_o
);
  logic [NUM_CH-1:0] hit;

  // decoder term ANDed with each source, then one wide OR
  for (genvar g = 0; g < NUM_CH; g++) begin : g_term
    assign hit[g] = src_i[g] & (sel_i == SEL_W'(g));
  end

  assign line_o = |hit;
endmodule

// File: rtl/tdm_rx_steer.sv
module tdm_rx_steer #(
  parameter int unsigned NUM_CH = tdm_pkg::TDM_CH_DEFAULT,
  localparam int unsigned SEL_W = tdm_pkg::tdm_sel_width(NUM_CH)
) (
  input  logic              line_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [NUM_CH-1:0] dst_o
);
  // each destination is the wire gated by its own decode line
  for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
    assign dst_o[g] = line_i & (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/tdm_link.sv
module tdm_link #(
  parameter int unsigned NUM_CH = tdm_pkg::TDM_CH_DEFAULT,
  localparam int unsigned SEL_W = tdm_pkg::tdm_sel_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [NUM_CH-1:0] src_in,
  output logic [NUM_CH-1:0] dst_out,
  output logic              line_out,
  output logic [SEL_W-1:0]  slot_idx
);
  logic [SEL_W-1:0] slot;
  logic             wire_bit;

  tdm_slot_ctr #(.NUM_CH(NUM_CH)) u_ctr (
    .clk(clk), .rst(rst), .en(en), .slot_o(slot)
  );

  tdm_tx_sel #(.NUM_CH(NUM_CH)) u_tx (
    .src_i(src_in), .sel_i(slot), .line_o(wire_bit)
  );

  tdm_rx_steer #(.NUM_CH(NUM_CH)) u_rx (
    .line_i(wire_bit), .sel_i(slot), .dst_o(dst_out)
  );

  assign line_out = wire_bit;
  assign slot_idx = slot;

  AST_LINE_PICK: assert property (@(posedge clk) disable iff (rst)
    wire_bit == src_in[slot]); // R2
  AST_DST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dst_out) && (dst_out[slot] == wire_bit)); // R3
  AST_NO_INVENT: assert property (@(posedge clk) disable iff (rst)
    !wire_bit |-> (dst_out == '0)); // R7
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
    dst_out[slot] == src_in[slot]); // R8
endmodule

// File: tb/test_tdm_link.sv
`timescale 1ns/1ps
module test_tdm_link;
  localparam int CH = 4;
  localparam int SW = 2;

  typedef struct {
    logic [SW-1:0] slot;
    logic [CH-1:0] src;
    logic          line;
    logic [CH-1:0] dst;
    string         slot_tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [CH-1:0] src_in = '0;
  logic [CH-1:0] dst_out;
  logic line_out;
  logic [SW-1:0] slot_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [SW-1:0] m_slot;
  string next_tag;

  always #2.5 clk = ~clk;

  tdm_link #(.NUM_CH(CH)) i_tdm_link (
    .clk(clk), .rst(rst), .en(en), .src_in(src_in),
    .dst_out(dst_out), .line_out(line_out), .slot_idx(slot_idx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: apply one slot, push its expectation, advance the model
  task automatic drive(input logic r, input logic e, input logic [CH-1:0] s);
    exp_t it;
    @(negedge clk);
    rst = r; en = e; src_in = s;
    it.slot = m_slot;
    it.src = s;
    it.line = s[m_slot];
    it.dst = CH'(s[m_slot]) << m_slot;
    it.slot_tag = next_tag;
    sb.push_back(it);
    if (r) begin
      next_tag = e ? "R9" : "R1";
      m_slot = '0;
    end else if (e) begin
      next_tag = (m_slot == SW'(CH - 1)) ? "R5" : "R4";
      m_slot = (m_slot == SW'(CH - 1)) ? '0 : m_slot + 1'b1;
    end else begin
      next_tag = "R6";
    end
  endtask

  // monitor: compare outputs away from the clock edge
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      check(it.slot_tag, 32'(slot_idx), 32'(it.slot));
      check("R2", 32'(line_out), 32'(it.line));
      check(it.src[it.slot] ? "R3" : "R7", 32'(dst_out), 32'(it.dst));
      check("R8", 32'(dst_out[it.slot]), 32'(it.src[it.slot]));
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    m_slot = '0;
    next_tag = "R1";
    // R1: reset state, counter paused
    drive(0, 0, 4'b1111);
    drive(0, 0, 4'b1111);
    // R4 R5: all-ones over two rotations
    for (int i = 0; i < 8; i++) drive(0, 1, 4'b1111);
    // R7: all-zero sources
    for (int i = 0; i < 8; i++) drive(0, 1, 4'b0000);
    // R8: each single-hot pattern across a full rotation
    for (int h = 0; h < CH; h++)
      for (int i = 0; i < CH; i++) drive(0, 1, CH'(1) << h);
    // R6: paused with changing sources
    for (int i = 0; i < 6; i++) drive(0, 0, CH'($urandom));
    // R9: reset together with enable mid-rotation
    drive(0, 1, 4'b1010);
    drive(1, 1, 4'b0110);
    drive(0, 1, 4'b1001);
    drive(1, 0, 4'b1111);
    // random mix of enable and data
    for (int i = 0; i < 60; i++) drive(0, ($urandom % 4) != 0, CH'($urandom));
    @(negedge clk);
    #2;
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule